// File: doc/BRIEF.md
# Transmit Flow Sampler and Key Compressor

This block sits beside one transmit queue and watches the already-parsed header fields of every outgoing packet. From that stream it picks out TCP connections that deserve a receive steering filter. For each chosen packet it builds the two 32-bit operands that a later hash stage consumes. The first is an uncompressed word carrying the flow class and the packet-type code. The second is a compressed word that folds ports, ethertype and every address word into 32 bits. Source and destination are swapped, so the key describes the flow as the receiving side will see it.

Choices are rate limited by an 8-bit per-queue counter. Every presented packet advances the counter. A packet becomes a candidate once the counter reaches the programmed rate. A SYN jumps the queue, a FIN is never taken, and a zero rate turns the whole block off. A chosen packet leaves as a single request on a valid/ready handshake, tagged with the queue index. While a request waits, further packets are still counted but cannot be chosen.

Top module: `tx_flow_sampler`

## Requirements
- R1: After reset `reqValid` is 0.
- R2: While `sampleRate` is 0 no request is raised and the sample counter keeps its value.
- R3: With `sampleRate` nonzero, every packet with `pktValid` high advances the counter by one, whatever its type. A qualifying packet is taken when the advanced count is at least `sampleRate`. Taking a packet clears the counter to 0.
- R4: A packet qualifies only when `pktType[2:0]` equals 4 (TCP). When `pktTunnel` is 0, `pktType[5:4]` must also equal 2'b10 (IP); when it is 1, bits 5:4 are not looked at.
- R5: A packet with `tcpFin` set is never taken, but it is still counted.
- R6: A qualifying packet with `tcpSyn` set and `tcpFin` clear is taken whatever the counter holds.
- R7: The counter saturates at 255 rather than wrapping.
- R8: `reqCommon` is formed as follows. Bits 31:16 hold `dstPort ^ etherType`, and bits 15:0 hold `srcPort`. The whole word is then XORed with the address words: words 0 and 1 of `addrWords` (bits 63:0) when `isIpv6` is 0, and all eight words when `isIpv6` is 1.
- R9: `reqInput` bits 31:24 are 0, and bits 15:8 are 0. Bits 23:16 hold the flow class: 2 for TCP over IPv4, 6 for TCP over IPv6. Bits 7:0 hold `pktType`.
- R10: A request appears in the cycle after the packet is taken. `reqValid` and the request words then stay unchanged until a cycle with `reqReady` high, after which `reqValid` falls. A packet presented while `reqValid` is high is not taken but is counted.
- R11: `reqQueue` carries the value of `queueIdx` at the time the packet was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sampleRate | input | 8 | Packets per sample; 0 disables |
| queueIdx | input | 7 | Index of the queue this block serves |
| pktValid | input | 1 | A parsed packet is presented this cycle |
| pktType | input | 8 | Packet-type code |
| pktTunnel | input | 1 | Packet is tunnelled |
| tcpSyn | input | 1 | TCP SYN flag |
| tcpFin | input | 1 | TCP FIN flag |
| srcPort | input | 16 | TCP source port |
| dstPort | input | 16 | TCP destination port |
| etherType | input | 16 | Ethertype word |
| isIpv6 | input | 1 | Addresses are IPv6 |
| addrWords | input | 256 | Eight 32-bit address words, word i at bits 32*i+31:32*i |
| reqValid | output | 1 | Add-filter request pending |
| reqReady | input | 1 | Consumer accepts the request |
| reqInput | output | 32 | Uncompressed key word |
| reqCommon | output | 32 | Compressed key word |
| reqQueue | output | 7 | Queue index of the request |

## Verification
The hardest state to reach is a saturated counter. Reaching it needs a long run of non-qualifying packets, and only a later qualifying packet against a high rate shows whether the count saturated or wrapped. The bench drives 300 non-TCP packets at rate 255 and then a plain TCP packet. A second hard case is a packet that arrives while a request is stalled: it must be counted but not taken. The random phase holds `reqReady` low about half the time so that such arrivals happen often, and a directed sequence stalls a SYN behind an earlier request.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  localparam logic [2:0] PT_L4_TCP   = 3'd4;
  localparam logic [1:0] PT_CLASS_IP = 2'b10;
  localparam logic [7:0] FLOW_TCP4   = 8'd2;
  localparam logic [7:0] FLOW_TCP6   = 8'd6;

  typedef struct packed {
    logic load;    // capture the request words this edge
  } tfs_strobe_t;
endpackage

// File: rtl/tfs_ctrl.sv
module tfs_ctrl
  import tfs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] sampleRate,
  input  logic             pktValid,
  input  logic [7:0]       pktType,
  input  logic             pktTunnel,
  input  logic             tcpSyn,
  input  logic             tcpFin,
  input  logic             reqReady,
  output logic             reqValid,
  output tfs_strobe_t      strobe
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] sampleCnt;
  logic [CNT_W-1:0] nextCnt;
  logic             tcpOk;
  logic             enabled;
  logic             sampleNow;

  always_comb begin
    enabled   = (sampleRate != '0);
    tcpOk     = (pktType[2:0] == PT_L4_TCP) &&
                (pktTunnel || (pktType[5:4] == PT_CLASS_IP));
    nextCnt   = (sampleCnt == CNT_MAX) ? CNT_MAX : sampleCnt + 1'b1;
    sampleNow = pktValid && enabled && tcpOk && !tcpFin && !reqValid &&
                (tcpSyn || (nextCnt >= sampleRate));
    strobe.load = sampleNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampleCnt <= '0;
      reqValid  <= 1'b0;
    end else begin
      if (pktValid && enabled)
        sampleCnt <= sampleNow ? '0 : nextCnt;
      if (sampleNow)
        reqValid <= 1'b1;
      else if (reqReady)
        reqValid <= 1'b0;
    end
  end

  AST_FIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid && tcpFin && !reqValid |=> !reqValid); // R5
  AST_RATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sampleRate == '0 && !reqValid |=> !reqValid); // R2
  AST_RATE_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sampleRate == '0 |=> $stable(sampleCnt)); // R2
  AST_SYN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid && enabled && tcpOk && tcpSyn && !tcpFin && !reqValid |=> reqValid); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !reqReady |=> reqValid); // R10
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pktValid |=> $stable(sampleCnt)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sampleCnt == CNT_MAX && pktValid && !reqValid && !sampleNow |=> sampleCnt == CNT_MAX); // R7
endmodule

// File: rtl/tfs_datapath.sv
module tfs_datapath
  import tfs_pkg::*;
#(
  parameter int ADDR_WORDS = 8,
  parameter int V4_WORDS   = 2,
  parameter int QIDX_W     = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  tfs_strobe_t            strobe,
  input  logic                   reqValid,
  input  logic                   reqReady,
  input  logic [7:0]             pktType,
  input  logic [15:0]            srcPort,
  input  logic [15:0]            dstPort,
  input  logic [15:0]            etherType,
  input  logic                   isIpv6,
  input  logic [ADDR_WORDS*32-1:0] addrWords,
  input  logic [QIDX_W-1:0]      queueIdx,
  output logic [31:0]            reqInput,
  output logic [31:0]            reqCommon,
  output logic [QIDX_W-1:0]      reqQueue
);
  logic [31:0] addrFold [ADDR_WORDS+1];
  logic [31:0] commonNext;
  logic [31:0] inputNext;

  assign addrFold[0] = '0;
  for (genvar w = 0; w < ADDR_WORDS; w++) begin : g_fold
    if (w < V4_WORDS) begin : g_always
      assign addrFold[w+1] = addrFold[w] ^ addrWords[w*32 +: 32];
    end else begin : g_v6only
      assign addrFold[w+1] = addrFold[w] ^ (isIpv6 ? addrWords[w*32 +: 32] : 32'h0);
    end
  end

  always_comb begin
    commonNext = {dstPort ^ etherType, srcPort} ^ addrFold[ADDR_WORDS];
    inputNext  = {8'h00, isIpv6 ? FLOW_TCP6 : FLOW_TCP4, 8'h00, pktType};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqInput  <= '0;
      reqCommon <= '0;
      reqQueue  <= '0;
    end else if (strobe.load) begin
      reqInput  <= inputNext;
      reqCommon <= commonNext;
      reqQueue  <= queueIdx;
    end
  end

  AST_WORDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !reqReady |=> $stable(reqInput) && $stable(reqCommon) && $stable(reqQueue)); // R10
  AST_FLOW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> (reqInput[23:16] == FLOW_TCP4 || reqInput[23:16] == FLOW_TCP6)); // R9
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> reqInput[31:24] == 8'h00 && reqInput[15:8] == 8'h00); // R9
endmodule

// File: rtl/tx_flow_sampler.sv
module tx_flow_sampler
  import tfs_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int QIDX_W     = 7,
  parameter int ADDR_WORDS = 8,
  parameter int V4_WORDS   = 2,
  localparam int ADDR_BITS = ADDR_WORDS * 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     sampleRate,
  input  logic [QIDX_W-1:0]    queueIdx,
  input  logic                 pktValid,
  input  logic [7:0]           pktType,
  input  logic                 pktTunnel,
  input  logic                 tcpSyn,
  input  logic                 tcpFin,
  input  logic [15:0]          srcPort,
  input  logic [15:0]          dstPort,
  input  logic [15:0]          etherType,
  input  logic                 isIpv6,
  input  logic [ADDR_BITS-1:0] addrWords,
  output logic                 reqValid,
  input  logic                 reqReady,
  output logic [31:0]          reqInput,
  output logic [31:0]          reqCommon,
  output logic [QIDX_W-1:0]    reqQueue
);
  tfs_strobe_t strobe;

  tfs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sampleRate(sampleRate),
    .pktValid(pktValid), .pktType(pktType), .pktTunnel(pktTunnel),
    .tcpSyn(tcpSyn), .tcpFin(tcpFin), .reqReady(reqReady),
    .reqValid(reqValid), .strobe(strobe)
  );

  tfs_datapath #(.ADDR_WORDS(ADDR_WORDS), .V4_WORDS(V4_WORDS), .QIDX_W(QIDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqValid(reqValid),
    .reqReady(reqReady), .pktType(pktType), .srcPort(srcPort),
    .dstPort(dstPort), .etherType(etherType), .isIpv6(isIpv6),
    .addrWords(addrWords), .queueIdx(queueIdx), .reqInput(reqInput),
    .reqCommon(reqCommon), .reqQueue(reqQueue)
  );
endmodule

// File: tb/sim_tx_flow_sampler.sv
module sim_tx_flow_sampler;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   sampleRate = 8'd20;
  logic [6:0]   queueIdx = 7'd5;
  logic         pktValid = 1'b0;
  logic [7:0]   pktType = 8'h00;
  logic         pktTunnel = 1'b0;
  logic         tcpSyn = 1'b0;
  logic         tcpFin = 1'b0;
  logic [15:0]  srcPort = '0, dstPort = '0, etherType = '0;
  logic         isIpv6 = 1'b0;
  logic [255:0] addrWords = '0;
  logic         reqValid;
  logic         reqReady = 1'b0;
  logic [31:0]  reqInput, reqCommon;
  logic [6:0]   reqQueue;

  int checks = 0;
  int fails = 0;

  // model state
  int          mCnt = 0;
  bit          mValid = 0;
  logic [31:0] mInput = '0, mCommon = '0;
  logic [6:0]  mQueue = '0;

  always #2 clk = ~clk;

  tx_flow_sampler u0 (
    .clk(clk), .rst_n(rst_n), .sampleRate(sampleRate), .queueIdx(queueIdx),
    .pktValid(pktValid), .pktType(pktType), .pktTunnel(pktTunnel),
    .tcpSyn(tcpSyn), .tcpFin(tcpFin), .srcPort(srcPort), .dstPort(dstPort),
    .etherType(etherType), .isIpv6(isIpv6), .addrWords(addrWords),
    .reqValid(reqValid), .reqReady(reqReady), .reqInput(reqInput),
    .reqCommon(reqCommon), .reqQueue(reqQueue)
  );

  function automatic bit isTcp(logic [7:0] pt, logic tun);
    return pt[2:0] == 3'd4 && (tun || pt[5:4] == 2'b10);
  endfunction

  function automatic logic [31:0] expCommon();
    logic [31:0] c = {dstPort ^ etherType, srcPort};
    for (int i = 0; i < 8; i++)
      if (i < 2 || isIpv6) c ^= addrWords[i*32 +: 32];
    return c;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs already set; predict, clock, compare
  task automatic step(string req);
    bit take = 0;
    int nc = mCnt;
    if (pktValid && sampleRate != 0) begin
      nc = (mCnt == 255) ? 255 : mCnt + 1;
      take = isTcp(pktType, pktTunnel) && !tcpFin && !mValid &&
             (tcpSyn || nc >= sampleRate);
    end
    if (mValid && reqReady) mValid = 0;
    if (take) begin
      mValid = 1; mCnt = 0;
      mInput = {8'h00, isIpv6 ? 8'd6 : 8'd2, 8'h00, pktType};
      mCommon = expCommon();
      mQueue = queueIdx;
    end else mCnt = nc;
    @(posedge clk);
    @(negedge clk);
    check(req, {31'd0, reqValid}, {31'd0, mValid});
    if (mValid) begin
      check("R9", reqInput, mInput);
      check("R8", reqCommon, mCommon);
      check("R11", {25'd0, reqQueue}, {25'd0, mQueue});
    end
  endtask

  task automatic setPkt(logic [7:0] pt, logic tun, logic syn, logic fin, logic v6);
    pktValid = 1'b1; pktType = pt; pktTunnel = tun; tcpSyn = syn; tcpFin = fin; isIpv6 = v6;
    srcPort = 16'($urandom); dstPort = 16'($urandom); etherType = 16'($urandom);
    for (int i = 0; i < 8; i++) addrWords[i*32 +: 32] = $urandom;
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    check("R1", {31'd0, reqValid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    reqReady = 1'b1;

    // R3: rate 3, non-TCP counted, third packet taken
    sampleRate = 8'd3;
    setPkt(8'h23, 0, 0, 0, 0); step("R3");
    setPkt(8'h24, 0, 0, 0, 0); step("R3");
    setPkt(8'h24, 0, 0, 0, 0); step("R3");
    pktValid = 0; step("R3");
    // R4: wrong class bits, tunnelled accepted
    setPkt(8'h14, 0, 1, 0, 0); step("R4");
    setPkt(8'h14, 1, 1, 0, 1); step("R4");
    setPkt(8'h25, 0, 1, 0, 0); step("R4");
    // R5: FIN with SYN, counter full
    setPkt(8'h24, 0, 0, 1, 0); step("R5");
    setPkt(8'h24, 0, 1, 1, 0); step("R5");
    // R6: SYN bypass at low count
    sampleRate = 8'd50;
    setPkt(8'h24, 0, 1, 0, 1); step("R6");
    // R2: rate zero
    sampleRate = 8'd0;
    for (int i = 0; i < 5; i++) begin setPkt(8'h24, 0, 1, 0, 0); step("R2"); end
    sampleRate = 8'd2;
    setPkt(8'h24, 0, 0, 0, 0); step("R2");
    setPkt(8'h24, 0, 0, 0, 0); step("R2");
    // R7: saturation
    sampleRate = 8'd255;
    for (int i = 0; i < 300; i++) begin setPkt(8'h11, 0, 0, 0, 0); step("R7"); end
    setPkt(8'h24, 0, 0, 0, 0); step("R7");
    // R10: stall, packet during pending is counted only
    reqReady = 1'b0; sampleRate = 8'd2;
    setPkt(8'h24, 0, 1, 0, 0); step("R10");
    setPkt(8'h24, 0, 1, 0, 1); step("R10");
    pktValid = 0; step("R10");
    reqReady = 1'b1; step("R10");
    setPkt(8'h24, 0, 0, 0, 0); step("R10");

    // random phase
    sampleRate = 8'd3;
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 3);
      logic [7:0] pt = (sel == 0) ? 8'h24 : (sel == 1) ? 8'h14 :
                       (sel == 2) ? 8'h2C : 8'($urandom);
      setPkt(pt, $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
             $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1);
      pktValid = $urandom_range(0, 4) != 0;
      reqReady = $urandom_range(0, 1) == 1;
      queueIdx = 7'($urandom);
      if (n % 500 == 499) sampleRate = 8'($urandom_range(0, 6));
      step("R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule